// File: doc/BRIEF.md
# GPIO Event Router

This block steers status events from sixteen general-purpose pins to one of two interrupt destinations. One destination is the system-management interrupt (SMI) and the other is the system-control interrupt (SCI). A 32-bit routing register holds a 2-bit code for each pin, and pin n owns bits [2n+1:2n]. A pin's event reaches a destination only when four conditions hold together: its status bit is set, the pin is configured as an input, its code selects that destination, and the enable for that destination is set for that pin.

A separate wake path does not use the routing code. While the platform reports a sleep state from S1 to S5, any implemented pin whose status and event enable are both set requests a wake. This holds whatever the pin's direction or code.

A parameter mask selects which pins exist. The routing fields of absent pins always read as zero and ignore writes. SMI, SCI and wake are level outputs, each registered once, and each stays high while a qualifying status bit stays set.

Top module: `gpio_event_router`

## Requirements
- R1: In reset the routing register reads all zeros, and smi_o, sci_o and wake_o are low.
- R2: A cycle with wr_en high loads wr_data into the routing register, which shows on route_rd from the next cycle on.
- R3: Fields of pins absent from IMPL_MASK always read 0, ignore writes, and produce no SMI, SCI or wake.
- R4: Code 2'b01 in pin n's field raises smi_o one cycle after gpio_sts[n], gpio_is_input[n] and smi_en[n] are all high. Without smi_en[n], it does not raise smi_o.
- R5: Code 2'b10 in pin n's field raises sci_o one cycle after gpio_sts[n], gpio_is_input[n] and gpe_en[n] are all high. Without gpe_en[n], it does not raise sci_o.
- R6: Code 2'b00 and the reserved code 2'b11 raise neither smi_o nor sci_o.
- R7: A pin with gpio_is_input[n] low causes no SMI or SCI, whatever its code.
- R8: When sleep_state is 1 to 5 (S1 to S5), wake_o rises one cycle after gpio_sts[n] and gpe_en[n] are both high. This holds regardless of pin n's code or direction.
- R9: wake_o stays low when sleep_state is 0 (S0) or 6 to 7 (unused encodings).
- R10: The outputs are levels: they stay high while the qualifying status is held, and they fall one cycle after it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the routing register |
| wr_data | input | 32 | Routing register write value |
| route_rd | output | 32 | Routing register contents (absent fields zero) |
| gpio_sts | input | 16 | Per-pin event status |
| gpio_is_input | input | 16 | Per-pin direction, 1 = input |
| smi_en | input | 16 | Per-pin SMI enable |
| gpe_en | input | 16 | Per-pin SCI/general-purpose-event enable, also the wake enable |
| sleep_state | input | 3 | Platform state, 0 = S0, 1..5 = S1..S5 |
| smi_o | output | 1 | SMI request level |
| sci_o | output | 1 | SCI request level |
| wake_o | output | 1 | Wake request level |

## Verification
The assertions assume that the pin inputs and sleep_state are synchronous to clk and are held at zero while reset is applied. Under that assumption, every $past term after reset refers to a defined sample. The stimulus drives all inputs only on the falling edge and starts each case from a clean routing write, so each output can be traced to a single set of inputs one edge earlier. The bench builds the design with one pin missing from the mask, so the absent-pin behaviour can be seen at the ports.

// File: rtl/gpio_rt_pkg.sv
package gpio_rt_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'b00,
        RT_SMI  = 2'b01,
        RT_SCI  = 2'b10,
        RT_RSVD = 2'b11
    } route_e;

    typedef struct packed {
        logic smi;
        logic sci;
        logic wake;
    } evt_t;

    // S1..S5 are encodings 1..5; 0 is working, 6 and 7 unused
    function automatic logic in_sleep(input logic [2:0] s);
        return (s >= 3'd1) && (s <= 3'd5);
    endfunction

    // Spread a per-pin mask into a per-field (2 bits per pin) mask
    function automatic logic [63:0] expand_mask(input logic [31:0] m, input int n);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < n && m[i]) r[2*i +: 2] = 2'b11;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_route_reg.sv
module gpio_route_reg #(
    parameter int          NUM_PINS  = 16,
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    localparam int         REG_W     = 2 * NUM_PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] route_q
);
    import gpio_rt_pkg::*;

    localparam logic [63:0] FULL_MASK = expand_mask(IMPL_MASK, NUM_PINS);

    logic [REG_W-1:0] route_d;
    logic [REG_W-1:0] keep_bits;

    // absent fields are tied to zero by construction of keep_bits
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_field
        assign keep_bits[2*i +: 2] = FULL_MASK[2*i +: 2];
    end

    always_comb begin
        route_d = route_q;
        if (wr_en) route_d = wr_data & keep_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= '0;
        else        route_q <= route_d;
    end

endmodule

// File: rtl/gpio_route_decode.sv
module gpio_route_decode #(
    parameter int          NUM_PINS  = 16,
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    localparam int         REG_W     = 2 * NUM_PINS
) (
    input  logic [REG_W-1:0]    route,
    input  logic [NUM_PINS-1:0] sts,
    input  logic [NUM_PINS-1:0] is_input,
    input  logic [NUM_PINS-1:0] smi_en,
    input  logic [NUM_PINS-1:0] gpe_en,
    output logic [NUM_PINS-1:0] smi_hit,
    output logic [NUM_PINS-1:0] sci_hit,
    output logic [NUM_PINS-1:0] wake_hit
);
    import gpio_rt_pkg::*;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (IMPL_MASK[i]) begin : g_impl
            route_e code;
            logic   armed;
            assign code        = route_e'(route[2*i +: 2]);
            assign armed       = sts[i] & is_input[i];
            assign smi_hit[i]  = armed & smi_en[i] & (code == RT_SMI);
            assign sci_hit[i]  = armed & gpe_en[i] & (code == RT_SCI);
            assign wake_hit[i] = sts[i] & gpe_en[i];
        end else begin : g_absent
            logic unused_in;
            assign unused_in   = ^{route[2*i +: 2], sts[i], is_input[i], smi_en[i], gpe_en[i]};
            assign smi_hit[i]  = 1'b0;
            assign sci_hit[i]  = 1'b0;
            assign wake_hit[i] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_event_merge.sv
module gpio_event_merge #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] smi_hit,
    input  logic [NUM_PINS-1:0] sci_hit,
    input  logic [NUM_PINS-1:0] wake_hit,
    input  logic [2:0]          sleep_state,
    output gpio_rt_pkg::evt_t   evt_q
);
    import gpio_rt_pkg::*;

    evt_t evt_d;

    always_comb begin
        evt_d      = '0;
        evt_d.smi  = |smi_hit;
        evt_d.sci  = |sci_hit;
        evt_d.wake = (|wake_hit) & in_sleep(sleep_state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

endmodule

// File: rtl/gpio_event_router.sv
module gpio_event_router #(
    parameter int          NUM_PINS  = 16,
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    localparam int         REG_W     = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    route_rd,
    input  logic [NUM_PINS-1:0] gpio_sts,
    input  logic [NUM_PINS-1:0] gpio_is_input,
    input  logic [NUM_PINS-1:0] smi_en,
    input  logic [NUM_PINS-1:0] gpe_en,
    input  logic [2:0]          sleep_state,
    output logic                smi_o,
    output logic                sci_o,
    output logic                wake_o
);
    import gpio_rt_pkg::*;

    logic [REG_W-1:0]    route_q;
    logic [NUM_PINS-1:0] smi_hit, sci_hit, wake_hit;
    evt_t                evt_q;

    gpio_route_reg #(.NUM_PINS(NUM_PINS), .IMPL_MASK(IMPL_MASK)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .route_q (route_q)
    );

    gpio_route_decode #(.NUM_PINS(NUM_PINS), .IMPL_MASK(IMPL_MASK)) dec_i (
        .route    (route_q),
        .sts      (gpio_sts),
        .is_input (gpio_is_input),
        .smi_en   (smi_en),
        .gpe_en   (gpe_en),
        .smi_hit  (smi_hit),
        .sci_hit  (sci_hit),
        .wake_hit (wake_hit)
    );

    gpio_event_merge #(.NUM_PINS(NUM_PINS)) mrg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .smi_hit     (smi_hit),
        .sci_hit     (sci_hit),
        .wake_hit    (wake_hit),
        .sleep_state (sleep_state),
        .evt_q       (evt_q)
    );

    assign route_rd = route_q;
    assign smi_o    = evt_q.smi;
    assign sci_o    = evt_q.sci;
    assign wake_o   = evt_q.wake;

endmodule

// File: rtl/gpio_event_router_chk.sv
module gpio_event_router_chk #(
    parameter int          NUM_PINS  = 16,
    parameter logic [31:0] IMPL_MASK = 32'h0000_FFFF,
    localparam int         REG_W     = 2 * NUM_PINS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [REG_W-1:0]    wr_data,
    input logic [REG_W-1:0]    route_rd,
    input logic [NUM_PINS-1:0] gpio_sts,
    input logic [NUM_PINS-1:0] gpio_is_input,
    input logic [NUM_PINS-1:0] smi_en,
    input logic [NUM_PINS-1:0] gpe_en,
    input logic [2:0]          sleep_state,
    input logic                smi_o,
    input logic                sci_o,
    input logic                wake_o
);
    import gpio_rt_pkg::*;

    localparam logic [63:0] FULL_MASK = expand_mask(IMPL_MASK, NUM_PINS);
    localparam logic [REG_W-1:0] FMASK = FULL_MASK[REG_W-1:0];

    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> route_rd == ($past(wr_data) & FMASK));

    p_absent_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (route_rd & ~FMASK) == '0);

    p_smi_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> $past(|(gpio_sts & gpio_is_input & smi_en)));

    p_sci_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sci_o |-> $past(|(gpio_sts & gpio_is_input & gpe_en)));

    p_wake_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(sleep_state) >= 3'd1 && $past(sleep_state) <= 3'd5));

    p_wake_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(|(gpio_sts & gpe_en)));

endmodule

bind gpio_event_router gpio_event_router_chk #(
    .NUM_PINS(NUM_PINS), .IMPL_MASK(IMPL_MASK)
) chk_i (.*);

// File: tb/gpio_event_router_tb_top.sv
module gpio_event_router_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NP         = 16;
    localparam logic [31:0] MASK       = 32'h0000_BFFF; // pin 14 absent

    typedef struct packed {
        logic [31:0] route;
        logic [15:0] sts;
        logic [15:0] isin;
        logic [15:0] smi;
        logic [15:0] gpe;
        logic [2:0]  slp;
        logic        e_smi;
        logic        e_sci;
        logic        e_wake;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 16'h0001, 16'h0001, 16'h0001, 16'h0000, 3'd0, 1'b1, 1'b0, 1'b0}, // R4 smi
        '{32'h0000_0001, 16'h0001, 16'h0001, 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0}, // R4 no enable
        '{32'h0000_0080, 16'h0008, 16'h0008, 16'h0000, 16'h0008, 3'd0, 1'b0, 1'b1, 1'b0}, // R5 sci
        '{32'h0000_0080, 16'h0008, 16'h0008, 16'h0008, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0}, // R5 no enable
        '{32'h0000_0C00, 16'h0020, 16'h0020, 16'h0020, 16'h0020, 3'd0, 1'b0, 1'b0, 1'b0}, // R6 reserved
        '{32'h0000_0000, 16'h0020, 16'h0020, 16'h0020, 16'h0020, 3'd0, 1'b0, 1'b0, 1'b0}, // R6 none
        '{32'h4000_0000, 16'h8000, 16'h0000, 16'h8000, 16'h8000, 3'd0, 1'b0, 1'b0, 1'b0}, // R7 output pin
        '{32'h0000_0000, 16'h0080, 16'h0000, 16'h0000, 16'h0080, 3'd3, 1'b0, 1'b0, 1'b1}, // R8 wake code 00
        '{32'h0000_8000, 16'h0080, 16'h0000, 16'h0000, 16'h0080, 3'd5, 1'b0, 1'b0, 1'b1}, // R8 wake, R7 no sci
        '{32'h0000_0000, 16'h0080, 16'h0080, 16'h0000, 16'h0080, 3'd0, 1'b0, 1'b0, 1'b0}, // R9 S0
        '{32'h0000_0000, 16'h0080, 16'h0080, 16'h0000, 16'h0080, 3'd6, 1'b0, 1'b0, 1'b0}, // R9 unused code
        '{32'h1000_0000, 16'h4000, 16'h4000, 16'h4000, 16'h4000, 3'd1, 1'b0, 1'b0, 1'b0}, // R3 absent pin
        '{32'h0000_0024, 16'h0006, 16'h0006, 16'h0002, 16'h0004, 3'd2, 1'b1, 1'b1, 1'b1}  // R4 R5 R8 mixed
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] route_rd;
    logic [15:0] gpio_sts = '0, gpio_is_input = '0, smi_en = '0, gpe_en = '0;
    logic [2:0]  sleep_state = '0;
    logic        smi_o, sci_o, wake_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_event_router #(.NUM_PINS(NP), .IMPL_MASK(MASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .route_rd(route_rd), .gpio_sts(gpio_sts), .gpio_is_input(gpio_is_input),
        .smi_en(smi_en), .gpe_en(gpe_en), .sleep_state(sleep_state),
        .smi_o(smi_o), .sci_o(sci_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        gpio_sts = '0; gpio_is_input = '0; smi_en = '0; gpe_en = '0; sleep_state = '0;
    endtask

    // write at one edge, outputs reflect new route and inputs at the next
    task automatic apply(input vec_t v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v.route;
        gpio_sts = v.sts; gpio_is_input = v.isin; smi_en = v.smi; gpe_en = v.gpe;
        sleep_state = v.slp;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 route", route_rd, 32'h0);
        check("R1 outs", {29'h0, smi_o, sci_o, wake_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("vec%0d smi", i),  {31'h0, smi_o},  {31'h0, VECS[i].e_smi});
            check($sformatf("vec%0d sci", i),  {31'h0, sci_o},  {31'h0, VECS[i].e_sci});
            check($sformatf("vec%0d wake", i), {31'h0, wake_o}, {31'h0, VECS[i].e_wake});
            clear_inputs();
        end

        // R2 and R3 readback: pin 14 field (bits 29:28) stays zero
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 R3 readback", route_rd, 32'hCFFF_FFFF);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h1234_5678;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 readback", route_rd, 32'h0234_5678);
        @(negedge clk);
        check("R2 hold without write", route_rd, 32'h0234_5678);

        // R10 level: pin 0 code 01, status held then cleared
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0000_0001;
        @(negedge clk);
        wr_en = 1'b0;
        gpio_sts = 16'h0001; gpio_is_input = 16'h0001; smi_en = 16'h0001;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 held", {31'h0, smi_o}, 32'h1);
        end
        gpio_sts = 16'h0000;
        @(negedge clk);
        check("R10 falls", {31'h0, smi_o}, 32'h0);

        // R1 reset mid-run clears routing
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", route_rd, 32'h0);
        clear_inputs();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule